// File: doc/BRIEF.md
# Master System Interrupt Router

This block collects 32 level-sensitive device interrupt lines and delivers one prioritised request to a single processor that software selects. Each line has a priority level from 0 to 15, taken from a table fixed by a parameter. A line whose level is 0 is never used. The router keeps a master pending register and a disable mask. The effective set is the pending bits that are not disabled, and the request carries the largest level found in that set. Bit 31 of the disable mask acts as a master switch: when it is set, no request is made.

Software reaches the block through a word-addressed port. Word 0 reads the pending bits. Word 1 reads the disable mask. Word 2 is write-only and enables sources, and word 3 is write-only and disables them. Word 4 reads and writes the target processor. Some bit positions of the disable mask are fixed and cannot be changed by any write.

On the output side, the router sends level set and clear pulses for the target processor's own pending register whenever a line rises or falls. It also sends a request strobe, with its level, to the target processor, and a wake pulse to that processor. The request is evaluated after a line rises or after an enable write. A processor that reports an outstanding interrupt through `cpu_busy` is woken but gets no strobe.

Top module: `sys_irq_router`

## Requirements
- R1: After reset the pending register reads 0x00000000, the disable mask reads 0x004DFF80, the target reads 0, and no strobe, wake or level pulse is active.
- R2: A read of word 0 returns the pending bits with bit 31 forced to 0. Word 1 returns the disable mask. Word 4 returns the target in bits 3:0 with all other bits zero. Every other word returns 0. `bus_rdata` follows `bus_addr` in the same cycle.
- R3: A write to word 2 clears each disable bit that is 1 in the written value, except at fixed positions. The new mask is readable in the cycle after the write.
- R4: A write to word 3 sets each disable bit that is 1 in the written value, except at fixed positions. It also clears the matching pending bits.
- R5: Disable-mask positions set in 0x4FB2007F never change from their reset value (0), whatever value is written to word 2 or word 3.
- R6: A write to word 4 stores the low 4 bits of the written value as the target processor.
- R7: In the cycle after a line with table level L ≠ 0 goes from 0 to 1, its pending bit reads 1. In that same cycle `lvl_set` has bit L at 1 for one cycle, and `lvl_cpu` holds the target that was in force when the line rose. A line whose level is 0 changes no pending bit and causes no pulse or request.
- R8: In the cycle after a line with level L ≠ 0 goes from 1 to 0, its pending bit reads 0. In that same cycle `lvl_clr` has bit L at 1 for one cycle. No request follows.
- R9: In the second cycle after a rising line or an enable write, if pending AND NOT disabled is nonzero and disable bit 31 is 0, the router evaluates a request. `req_valid` then pulses for one cycle with `req_level` equal to the largest table level among the effective bits and `req_cpu` equal to the target.
- R10: While disable bit 31 is 1, no request is evaluated, so neither `req_valid` nor `cpu_wake` pulses.
- R11: Every evaluated request pulses `cpu_wake` at the target's bit only. `req_valid` stays 0 if `cpu_busy` is set for the target in the evaluation cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_lines | input | 32 | Device interrupt lines, level sensitive |
| cpu_busy | input | 16 | Per-processor outstanding-interrupt flag |
| bus_addr | input | 3 | Word address of register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| req_valid | output | 1 | One-cycle request strobe |
| req_level | output | 4 | Level of the request |
| req_cpu | output | 4 | Processor the request is for |
| cpu_wake | output | 16 | One-hot wake pulse |
| lvl_set | output | 16 | Level bits to set in the target's pending register |
| lvl_clr | output | 16 | Level bits to clear in the target's pending register |
| lvl_cpu | output | 4 | Processor the level pulses are for |

## Verification
The bench uses the default table, which maps line i to level i mod 16. Several lines are raised in turn, so that a lower level arriving under a higher one shows that the maximum is kept rather than the newest level. A line that is pending but masked is raised to show that it is left out of the reduction until an enable write admits it. A write of all ones to the disable word, followed by an enable write of only the fixed positions, separates the writable bits from the locked ones and exercises the master-disable bit. A busy target tells wake apart from request. A level-0 line and a falling line show which events start an evaluation.

// File: rtl/sir_pkg.sv
package sir_pkg;

    localparam int unsigned SRC_W  = 32;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned GDIS_BIT = 31;

    // positions of the disable mask that no write may alter
    localparam logic [SRC_W-1:0] LOCK_MASK = 32'h4FB2_007F;
    // disable mask after reset
    localparam logic [SRC_W-1:0] DIS_RESET = 32'h004D_FF80;

    typedef enum logic [ADDR_W-1:0] {
        WA_PEND   = 3'd0,
        WA_DIS    = 3'd1,
        WA_ENABLE = 3'd2,
        WA_MASK   = 3'd3,
        WA_TARGET = 3'd4
    } word_addr_e;

endpackage

// File: rtl/sir_line_front.sv
module sir_line_front
    import sir_pkg::*;
#(
    parameter int unsigned LVL_W = 4,
    parameter logic [SRC_W*LVL_W-1:0] LEVEL_MAP = 128'hFEDC_BA98_7654_3210_FEDC_BA98_7654_3210,
    localparam int unsigned NLVL = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] irq_in,
    output logic [SRC_W-1:0] rise,
    output logic [SRC_W-1:0] fall,
    output logic [NLVL-1:0]  set_lvls,
    output logic [NLVL-1:0]  clr_lvls
);

    logic [SRC_W-1:0] line_d, line_q;
    logic [SRC_W-1:0] live;

    for (genvar i = 0; i < SRC_W; i++) begin : g_line
        assign live[i] = (LEVEL_MAP[i*LVL_W +: LVL_W] != '0);
        assign rise[i] = live[i] &  irq_in[i] & ~line_q[i];
        assign fall[i] = live[i] & ~irq_in[i] &  line_q[i];
    end

    always_comb begin
        line_d   = irq_in;
        set_lvls = '0;
        clr_lvls = '0;
        for (int i = 0; i < SRC_W; i++) begin
            if (rise[i]) set_lvls[LEVEL_MAP[i*LVL_W +: LVL_W]] = 1'b1;
            if (fall[i]) clr_lvls[LEVEL_MAP[i*LVL_W +: LVL_W]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

endmodule

// File: rtl/sir_level_max.sv
module sir_level_max
    import sir_pkg::*;
#(
    parameter int unsigned LVL_W = 4,
    parameter logic [SRC_W*LVL_W-1:0] LEVEL_MAP = 128'hFEDC_BA98_7654_3210_FEDC_BA98_7654_3210,
    localparam int unsigned DEPTH = $clog2(SRC_W)
) (
    input  logic [SRC_W-1:0] active,
    output logic [LVL_W-1:0] max_lvl
);

    for (genvar s = 0; s <= DEPTH; s++) begin : g_stg
        localparam int unsigned CNT = SRC_W >> s;
        logic [LVL_W-1:0] v [CNT];
        if (s == 0) begin : g_leaf
            for (genvar i = 0; i < CNT; i++) begin : g_in
                assign v[i] = active[i] ? LEVEL_MAP[i*LVL_W +: LVL_W] : '0;
            end
        end else begin : g_red
            for (genvar j = 0; j < CNT; j++) begin : g_pair
                assign v[j] = (g_stg[s-1].v[2*j] > g_stg[s-1].v[2*j+1])
                            ? g_stg[s-1].v[2*j] : g_stg[s-1].v[2*j+1];
            end
        end
    end

    assign max_lvl = g_stg[DEPTH].v[0];

endmodule

// File: rtl/sir_bus_port.sv
module sir_bus_port
    import sir_pkg::*;
#(
    parameter int unsigned CPU_W = 4
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [SRC_W-1:0]  bus_wdata,
    input  logic [SRC_W-1:0]  pend,
    input  logic [SRC_W-1:0]  dis,
    input  logic [CPU_W-1:0]  tgt,
    output logic              ena_we,
    output logic [SRC_W-1:0]  ena_bits,
    output logic [SRC_W-1:0]  dis_bits,
    output logic              tgt_we,
    output logic [CPU_W-1:0]  tgt_val,
    output logic [SRC_W-1:0]  rdata
);

    logic [SRC_W-1:0] wr_free;

    assign wr_free  = bus_wdata & ~LOCK_MASK;
    assign ena_we   = bus_wr && (bus_addr == WA_ENABLE);
    assign ena_bits = ena_we ? wr_free : '0;
    assign dis_bits = (bus_wr && (bus_addr == WA_MASK)) ? wr_free : '0;
    assign tgt_we   = bus_wr && (bus_addr == WA_TARGET);
    assign tgt_val  = bus_wdata[CPU_W-1:0];

    always_comb begin
        rdata = '0;
        case (bus_addr)
            WA_PEND:   rdata = pend & ~(SRC_W'(1) << GDIS_BIT);
            WA_DIS:    rdata = dis;
            WA_TARGET: rdata = SRC_W'(tgt);
            default:   rdata = '0;
        endcase
    end

endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
    import sir_pkg::*;
#(
    parameter int unsigned LVL_W = 4,
    parameter int unsigned CPU_W = 4,
    parameter logic [SRC_W*LVL_W-1:0] LEVEL_MAP = 128'hFEDC_BA98_7654_3210_FEDC_BA98_7654_3210,
    localparam int unsigned NLVL = 1 << LVL_W,
    localparam int unsigned NUM_CPUS = 1 << CPU_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_W-1:0]    irq_lines,
    input  logic [NUM_CPUS-1:0] cpu_busy,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [SRC_W-1:0]    bus_wdata,
    output logic [SRC_W-1:0]    bus_rdata,
    output logic                req_valid,
    output logic [LVL_W-1:0]    req_level,
    output logic [CPU_W-1:0]    req_cpu,
    output logic [NUM_CPUS-1:0] cpu_wake,
    output logic [NLVL-1:0]     lvl_set,
    output logic [NLVL-1:0]     lvl_clr,
    output logic [CPU_W-1:0]    lvl_cpu
);

    typedef struct packed {
        logic [SRC_W-1:0]    pend;
        logic [SRC_W-1:0]    dis;
        logic [CPU_W-1:0]    tgt;
        logic [NLVL-1:0]     lvl_set;
        logic [NLVL-1:0]     lvl_clr;
        logic [CPU_W-1:0]    lvl_cpu;
        logic                trig;
        logic                req_valid;
        logic [LVL_W-1:0]    req_level;
        logic [CPU_W-1:0]    req_cpu;
        logic [NUM_CPUS-1:0] wake;
    } state_t;

    localparam state_t ST_RESET = '{
        pend:      '0,
        dis:       DIS_RESET,
        tgt:       '0,
        lvl_set:   '0,
        lvl_clr:   '0,
        lvl_cpu:   '0,
        trig:      1'b0,
        req_valid: 1'b0,
        req_level: '0,
        req_cpu:   '0,
        wake:      '0
    };

    state_t state_d, state_q;

    logic [SRC_W-1:0] rise, fall;
    logic [NLVL-1:0]  set_lvls, clr_lvls;
    logic             ena_we, tgt_we;
    logic [SRC_W-1:0] ena_bits, dis_bits;
    logic [CPU_W-1:0] tgt_val;
    logic [SRC_W-1:0] eff;
    logic [LVL_W-1:0] top_lvl;
    logic             eval;
    logic [SRC_W-1:0] dis_vec;

    sir_line_front #(
        .LVL_W     (LVL_W),
        .LEVEL_MAP (LEVEL_MAP)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_in   (irq_lines),
        .rise     (rise),
        .fall     (fall),
        .set_lvls (set_lvls),
        .clr_lvls (clr_lvls)
    );

    sir_bus_port #(
        .CPU_W (CPU_W)
    ) u_bus (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .pend      (state_q.pend),
        .dis       (state_q.dis),
        .tgt       (state_q.tgt),
        .ena_we    (ena_we),
        .ena_bits  (ena_bits),
        .dis_bits  (dis_bits),
        .tgt_we    (tgt_we),
        .tgt_val   (tgt_val),
        .rdata     (bus_rdata)
    );

    assign eff = state_q.pend & ~state_q.dis;

    sir_level_max #(
        .LVL_W     (LVL_W),
        .LEVEL_MAP (LEVEL_MAP)
    ) u_max (
        .active  (eff),
        .max_lvl (top_lvl)
    );

    assign eval = state_q.trig && (eff != '0) && !state_q.dis[GDIS_BIT];

    always_comb begin
        state_d = state_q;
        // line edges first, then a disable write drops pending bits it masks
        state_d.pend = (state_q.pend | rise) & ~fall & ~dis_bits;
        state_d.dis  = (state_q.dis | dis_bits) & ~ena_bits;
        if (tgt_we) state_d.tgt = tgt_val;

        state_d.lvl_set = set_lvls;
        state_d.lvl_clr = clr_lvls;
        state_d.lvl_cpu = state_q.tgt;

        state_d.trig      = (rise != '0) || ena_we;
        state_d.req_valid = eval && !cpu_busy[state_q.tgt];
        state_d.req_level = (eval && !cpu_busy[state_q.tgt]) ? top_lvl : '0;
        state_d.req_cpu   = state_q.tgt;
        state_d.wake      = eval ? (NUM_CPUS'(1) << state_q.tgt) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RESET;
        else        state_q <= state_d;
    end

    assign dis_vec   = state_q.dis;
    assign req_valid = state_q.req_valid;
    assign req_level = state_q.req_level;
    assign req_cpu   = state_q.req_cpu;
    assign cpu_wake  = state_q.wake;
    assign lvl_set   = state_q.lvl_set;
    assign lvl_clr   = state_q.lvl_clr;
    assign lvl_cpu   = state_q.lvl_cpu;

endmodule

// File: rtl/sir_router_chk.sv
module sir_router_chk
    import sir_pkg::*;
#(
    parameter int unsigned LVL_W = 4,
    parameter int unsigned CPU_W = 4,
    localparam int unsigned NLVL = 1 << LVL_W,
    localparam int unsigned NUM_CPUS = 1 << CPU_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [SRC_W-1:0]    bus_rdata,
    input logic [SRC_W-1:0]    dis_vec,
    input logic                req_valid,
    input logic [LVL_W-1:0]    req_level,
    input logic [CPU_W-1:0]    req_cpu,
    input logic [NUM_CPUS-1:0] cpu_wake,
    input logic [NLVL-1:0]     lvl_set,
    input logic [NLVL-1:0]     lvl_clr
);

    // R2
    pend_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == WA_PEND) |-> !bus_rdata[GDIS_BIT]);

    // R6
    tgt_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == WA_TARGET) |-> (bus_rdata[SRC_W-1:CPU_W] == '0));

    // R5
    lock_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_vec & LOCK_MASK) == (DIS_RESET & LOCK_MASK));

    // R9
    req_level_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_level != '0));

    // R11
    wake_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_wake));

    // R11
    req_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (cpu_wake == (NUM_CPUS'(1) << req_cpu)));

    // R7
    lvl_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lvl_set[0] && !lvl_clr[0]);

endmodule

bind sys_irq_router sir_router_chk #(
    .LVL_W (LVL_W),
    .CPU_W (CPU_W)
) u_router_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .dis_vec   (dis_vec),
    .req_valid (req_valid),
    .req_level (req_level),
    .req_cpu   (req_cpu),
    .cpu_wake  (cpu_wake),
    .lvl_set   (lvl_set),
    .lvl_clr   (lvl_clr)
);

// File: tb/test_sys_irq_router.sv
module test_sys_irq_router;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_lines = '0;
    logic [15:0] cpu_busy = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_valid;
    logic [3:0]  req_level;
    logic [3:0]  req_cpu;
    logic [15:0] cpu_wake;
    logic [15:0] lvl_set;
    logic [15:0] lvl_clr;
    logic [3:0]  lvl_cpu;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int lvl;
        int cpu;
    } exp_t;
    exp_t sbq[$];

    always #(CLK_P/2) clk = ~clk;

    sys_irq_router i_sys_irq_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_lines (irq_lines),
        .cpu_busy  (cpu_busy),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .req_valid (req_valid),
        .req_level (req_level),
        .req_cpu   (req_cpu),
        .cpu_wake  (cpu_wake),
        .lvl_set   (lvl_set),
        .lvl_clr   (lvl_clr),
        .lvl_cpu   (lvl_cpu)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] v);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        step(1);
        bus_wr    = 1'b0;
    endtask

    task automatic push_req(input int lvl, input int cpu);
        exp_t e;
        e.lvl = lvl;
        e.cpu = cpu;
        sbq.push_back(e);
    endtask

    // monitor: every strobe must match the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && req_valid) begin
            n_cmp++;
            if (sbq.size() == 0) begin
                n_bad++;
                $display("FAIL R9: unexpected request actual lvl %0d cpu %0d expected none",
                         req_level, req_cpu);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (int'(req_level) != e.lvl || int'(req_cpu) != e.cpu) begin
                    n_bad++;
                    $display("FAIL R9: request actual lvl %0d cpu %0d expected lvl %0d cpu %0d",
                             req_level, req_cpu, e.lvl, e.cpu);
                end
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state, R2 read map
        rd_check("R1 pend", 3'd0, 32'h0);
        rd_check("R1 dis", 3'd1, 32'h004D_FF80);
        rd_check("R1 tgt", 3'd4, 32'h0);
        check("R1 no strobe", {31'd0, req_valid}, 32'h0);
        check("R1 no pulse", {16'd0, lvl_set}, 32'h0);
        rd_check("R2 unused word", 3'd5, 32'h0);

        // R7 rising line 5 (level 5) -> set pulse, pending, request
        push_req(5, 0);
        irq_lines[5] = 1'b1;
        step(1);
        check("R7 set pulse", {16'd0, lvl_set}, 32'h0000_0020);
        check("R7 set cpu", {28'd0, lvl_cpu}, 32'h0);
        rd_check("R7 pend", 3'd0, 32'h0000_0020);
        step(3);
        check("R7 pulse one cycle", {16'd0, lvl_set}, 32'h0);

        // R9 lower level under a higher one keeps the maximum
        push_req(5, 0);
        irq_lines[3] = 1'b1;
        step(1);
        check("R7 set pulse 3", {16'd0, lvl_set}, 32'h0000_0008);
        step(3);

        // R9 masked line pends but is excluded from the maximum
        push_req(5, 0);
        irq_lines[10] = 1'b1;
        step(1);
        rd_check("R7 pend masked", 3'd0, 32'h0000_0428);
        step(3);

        // R3 enable line 10 -> request at level 10
        push_req(10, 0);
        wr(3'd2, 32'h0000_0400);
        rd_check("R3 enable", 3'd1, 32'h004D_FB80);
        step(3);

        // R4 R5 disable everything writable, pending drops writable bits
        wr(3'd3, 32'hFFFF_FFFF);
        rd_check("R5 disable all", 3'd1, 32'hB04D_FF80);
        rd_check("R4 pend cleared", 3'd0, 32'h0000_0028);
        step(2);

        // R5 enable on locked bits only changes nothing; R10 no request
        wr(3'd2, 32'h4FB2_007F);
        rd_check("R5 locked enable", 3'd1, 32'hB04D_FF80);
        step(3);

        // R10 global disable blocks request for line 24 (level 8)
        irq_lines[24] = 1'b1;
        step(1);
        check("R7 set pulse 8", {16'd0, lvl_set}, 32'h0000_0100);
        step(1);
        check("R10 no wake", {16'd0, cpu_wake}, 32'h0);
        step(2);

        // R10 clearing bit 31 releases the request
        push_req(8, 0);
        wr(3'd2, 32'h8000_0000);
        rd_check("R3 gdis clear", 3'd1, 32'h304D_FF80);
        step(3);

        // R6 target keeps low 4 bits
        wr(3'd4, 32'h0000_01F3);
        rd_check("R6 target", 3'd4, 32'h0000_0003);

        // R11 busy target: wake but no strobe
        cpu_busy[3] = 1'b1;
        irq_lines[6] = 1'b1;
        step(1);
        check("R7 set cpu 3", {28'd0, lvl_cpu}, 32'h3);
        check("R7 set pulse 6", {16'd0, lvl_set}, 32'h0000_0040);
        step(1);
        check("R11 no strobe busy", {31'd0, req_valid}, 32'h0);
        check("R11 wake", {16'd0, cpu_wake}, 32'h0000_0008);
        step(2);
        cpu_busy = '0;

        // R7 level-0 line 16 is ignored
        irq_lines[16] = 1'b1;
        step(1);
        check("R7 level0 pulse", {16'd0, lvl_set}, 32'h0);
        rd_check("R7 level0 pend", 3'd0, 32'h0100_0068);
        step(1);
        check("R7 level0 wake", {16'd0, cpu_wake}, 32'h0);
        step(2);

        // R8 falling line 5
        irq_lines[5] = 1'b0;
        step(1);
        check("R8 clr pulse", {16'd0, lvl_clr}, 32'h0000_0020);
        check("R8 clr cpu", {28'd0, lvl_cpu}, 32'h3);
        rd_check("R8 pend", 3'd0, 32'h0100_0048);
        step(1);
        check("R8 no wake", {16'd0, cpu_wake}, 32'h0);
        step(2);

        // R3 enable bit 29 (nothing pending there) -> level 8 to cpu 3
        push_req(8, 3);
        wr(3'd2, 32'h2000_0000);
        rd_check("R3 enable 29", 3'd1, 32'h104D_FF80);
        step(3);

        // R9 line 29 (level 13) becomes the maximum
        push_req(13, 3);
        irq_lines[29] = 1'b1;
        step(4);

        // R2 line 31 (level 15) pends but reads as zero at bit 31
        push_req(15, 3);
        irq_lines[31] = 1'b1;
        step(1);
        rd_check("R2 bit31 hidden", 3'd0, 32'h2100_0048);
        step(4);

        check("R9 scoreboard drained", sbq.size(), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule